// File: doc/BRIEF.md
# Wake and Suspend Event Controller

This block turns an activation-tone-detect line into wake signalling for the host. It counts only a low-to-high transition of that line as a wake event. A steady high level is not an event. What the event does depends on a bus-mode strap, which is captured once after reset.

In PCI mode the event sets an interrupt flag. If the power-management enable is set, it also pulls the open-drain power-management event line low. That pull-down has its own asynchronous path straight from the detect line, so it works even while the clock is stopped. The interrupt flag and the pull-down both stay set until software sends a one-cycle clear pulse.

In USB mode the block keeps a suspend state. Software enters that state with an explicit request, and a wake event leaves it. The suspend state drives a complementary pair of indications and an internal activity enable.

Top module: `wake_evt_ctrl`

## Requirements
- R1: A wake event is a rising edge of `detect_i`, seen through a synchronizer of `SYNC_STAGES` flops. If `detect_i` is already high when reset is released, no event occurs. Holding the line high produces exactly one event.
- R2: In PCI mode (`usb_mode_i`=0) with `pme_en_i`=1, a wake event sets `pme_pull_o`=1, meaning the line is pulled low.
- R3: In PCI mode with `pme_en_i`=0, a wake event leaves `pme_pull_o` at 0.
- R4: In PCI mode, every wake event sets `irq_o`=1 by the third rising clock edge after the detect rise, whatever the value of `pme_en_i`.
- R5: `irq_o` and `pme_pull_o` stay set until a one-cycle `evt_clr_i` pulse. `irq_o` clears at the clock edge that samples the pulse. `pme_pull_o` clears within one more edge.
- R6: With `pme_en_i`=1 in PCI mode, a rising edge on `detect_i` sets `pme_pull_o` while the clock is stopped.
- R7: In USB mode, a `suspend_req_i` pulse sets `suspend_o`=1, `suspend_n_o`=0 and `active_o`=0 at the next clock edge. `suspend_n_o` is always the inverse of `suspend_o`.
- R8: In USB mode, a wake event while suspended returns the block to `suspend_o`=0 and `active_o`=1. In USB mode, `irq_o` and `pme_pull_o` never assert.
- R9: In PCI mode, `suspend_req_i` is ignored: `suspend_o` stays 0 and `active_o` stays 1.
- R10: During reset and right after it, `pme_pull_o`=0, `irq_o`=0, `suspend_o`=0, `suspend_n_o`=1 and `active_o`=1.
- R11: `usb_mode_i` is captured on the first clock edge after reset. Later changes to it have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| detect_i | input | 1 | Activation-tone-detect line, asynchronous |
| usb_mode_i | input | 1 | Bus-mode strap: 0 selects PCI, 1 selects USB |
| pme_en_i | input | 1 | Power-management event enable |
| suspend_req_i | input | 1 | Software request to suspend (USB mode) |
| evt_clr_i | input | 1 | One-cycle clear for the interrupt flag and the event line |
| pme_pull_o | output | 1 | 1 = pull the open-drain event line low; 0 = high impedance |
| irq_o | output | 1 | Interrupt flag |
| suspend_o | output | 1 | Suspend indication |
| suspend_n_o | output | 1 | Inverted suspend indication |
| active_o | output | 1 | Internal activity enable |

## Verification
The bench builds the block with the default `SYNC_STAGES`=2. This makes the three-edge detect-to-interrupt latency and the reset priming window short and exactly countable. The bench gives each mode its own reset, so both strap values are covered, including a strap change after capture. Gating the bench clock reaches the clockless event path. Random sequences of enable values, wake pulses and clears exercise the persistence and the gating of the flags.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic {
    BUS_PCI = 1'b0,
    BUS_USB = 1'b1
  } bus_mode_e;

  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } susp_state_e;
endpackage

// File: rtl/wake_edge_sync.sv
module wake_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  localparam int PRIME = STAGES + 1;
  localparam int CW    = $clog2(PRIME + 1);
  localparam logic [CW-1:0] PRIME_V = CW'(PRIME);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic [CW-1:0]     prime_q;
  logic              ready;

  assign ready = (prime_q == PRIME_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      prime_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
      if (!ready) prime_q <= prime_q + 1'b1;
    end
  end

  // no edge until the chain and history hold real samples
  assign rise_o = ready & sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/wake_pme_latch.sv
module wake_pme_latch (
  input  logic det_i,
  input  logic arm_i,
  input  logic clr_i,
  input  logic rst_ni,
  output logic pme_o
);
  logic kill_n;
  logic pme_q;

  assign kill_n = rst_ni & ~clr_i;

  // clocked by the raw detect line: works with the block clock stopped
  always_ff @(posedge det_i or negedge kill_n) begin
    if (!kill_n)    pme_q <= 1'b0;
    else if (arm_i) pme_q <= 1'b1;
  end

  assign pme_o = pme_q;
endmodule

// File: rtl/wake_suspend_fsm.sv
module wake_suspend_fsm
  import wake_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic usb_i,
  input  logic req_i,
  input  logic wake_i,
  output logic asleep_o
);
  susp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AWAKE:  if (usb_i && req_i) state_d = ST_ASLEEP;
      ST_ASLEEP: if (wake_i)         state_d = ST_AWAKE;
      default:                       state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_AWAKE;
    else         state_q <= state_d;
  end

  assign asleep_o = (state_q == ST_ASLEEP);
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
  import wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic detect_i,
  input  logic usb_mode_i,
  input  logic pme_en_i,
  input  logic suspend_req_i,
  input  logic evt_clr_i,
  output logic pme_pull_o,
  output logic irq_o,
  output logic suspend_o,
  output logic suspend_n_o,
  output logic active_o
);
  bus_mode_e mode_q;
  logic      cap_q;
  logic      usb_mode_q;
  logic      pci_live;
  logic      clr_q;
  logic      irq_q;
  logic      rise;
  logic      asleep;

  // strap captured once, first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= BUS_PCI;
      cap_q  <= 1'b0;
    end else if (!cap_q) begin
      mode_q <= bus_mode_e'(usb_mode_i);
      cap_q  <= 1'b1;
    end
  end

  assign usb_mode_q = (mode_q == BUS_USB);
  assign pci_live   = cap_q & ~usb_mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b0;
    else         clr_q <= evt_clr_i;
  end

  wake_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (detect_i),
    .rise_o  (rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               irq_q <= 1'b0;
    else if (rise && pci_live) irq_q <= 1'b1;
    else if (evt_clr_i)        irq_q <= 1'b0;
  end

  wake_pme_latch u_pme (
    .det_i  (detect_i),
    .arm_i  (pme_en_i & pci_live),
    .clr_i  (clr_q),
    .rst_ni (rst_ni),
    .pme_o  (pme_pull_o)
  );

  wake_suspend_fsm u_susp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .usb_i    (usb_mode_q & cap_q),
    .req_i    (suspend_req_i),
    .wake_i   (rise),
    .asleep_o (asleep)
  );

  assign irq_o       = irq_q;
  assign suspend_o   = asleep;
  assign suspend_n_o = ~asleep;
  assign active_o    = ~asleep;
endmodule

// File: rtl/wake_evt_ctrl_chk.sv
module wake_evt_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic evt_clr_i,
  input logic suspend_req_i,
  input logic pme_pull_o,
  input logic irq_o,
  input logic suspend_o,
  input logic suspend_n_o,
  input logic active_o,
  input logic usb_mode_q,
  input logic cap_q
);
  // R7: complementary suspend pair
  a_r7_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o != suspend_n_o);

  // R7: suspend only entered on request
  a_r7_req_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(suspend_o) |-> $past(suspend_req_i));

  // R5: irq drops only after a clear
  a_r5_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(evt_clr_i));

  // R8: no host signalling in USB mode
  a_r8_usb_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q && usb_mode_q) |-> (!irq_o && !pme_pull_o));

  // R9: no suspend in PCI mode
  a_r9_pci_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q && !usb_mode_q) |-> (!suspend_o && active_o));

  // R11: strap held after capture
  a_r11_strap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cap_q) |-> $stable(usb_mode_q));
endmodule

bind wake_evt_ctrl wake_evt_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .evt_clr_i     (evt_clr_i),
  .suspend_req_i (suspend_req_i),
  .pme_pull_o    (pme_pull_o),
  .irq_o         (irq_o),
  .suspend_o     (suspend_o),
  .suspend_n_o   (suspend_n_o),
  .active_o      (active_o),
  .usb_mode_q    (usb_mode_q),
  .cap_q         (cap_q)
);

// File: tb/wake_evt_ctrl_test.sv
module wake_evt_ctrl_test;
  logic clk = 1'b0;
  logic clk_run = 1'b1;
  logic rst_ni = 1'b0;
  logic detect_i = 1'b0;
  logic usb_mode_i = 1'b0;
  logic pme_en_i = 1'b0;
  logic suspend_req_i = 1'b0;
  logic evt_clr_i = 1'b0;
  logic pme_pull_o, irq_o, suspend_o, suspend_n_o, active_o;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_irq, exp_pme, exp_susp;

  always #2 clk = clk_run ? ~clk : 1'b0;

  wake_evt_ctrl uut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .detect_i      (detect_i),
    .usb_mode_i    (usb_mode_i),
    .pme_en_i      (pme_en_i),
    .suspend_req_i (suspend_req_i),
    .evt_clr_i     (evt_clr_i),
    .pme_pull_o    (pme_pull_o),
    .irq_o         (irq_o),
    .suspend_o     (suspend_o),
    .suspend_n_o   (suspend_n_o),
    .active_o      (active_o)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic mode);
    rst_ni = 1'b0;
    usb_mode_i = mode;
    suspend_req_i = 1'b0;
    evt_clr_i = 1'b0;
    pme_en_i = 1'b0;
    cyc(3);
    rst_ni = 1'b1;
  endtask

  task automatic wake_pulse();
    detect_i = 1'b1; cyc(6);
    detect_i = 1'b0; cyc(6);
  endtask

  task automatic clear_pulse();
    evt_clr_i = 1'b1; cyc(1);
    evt_clr_i = 1'b0; cyc(3);
  endtask

  task automatic req_pulse();
    suspend_req_i = 1'b1; cyc(1);
    suspend_req_i = 1'b0; cyc(2);
  endtask

  // reference model updates
  function automatic void model_wake_pci(logic en);
    exp_irq = 1'b1;
    if (en) exp_pme = 1'b1;
  endfunction

  function automatic void model_clear();
    exp_irq = 1'b0;
    exp_pme = 1'b0;
  endfunction

  task automatic chk_pci(string req);
    chk(req, "irq_o", irq_o, exp_irq);
    chk(req, "pme_pull_o", pme_pull_o, exp_pme);
  endtask

  task automatic chk_usb(string req);
    chk(req, "suspend_o", suspend_o, exp_susp);
    chk(req, "suspend_n_o", suspend_n_o, ~exp_susp);
    chk(req, "active_o", active_o, ~exp_susp);
    chk(req, "irq_o", irq_o, 1'b0);
    chk(req, "pme_pull_o", pme_pull_o, 1'b0);
  endtask

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));

    // R10 reset values, PCI mode; R1 detect high across reset release
    detect_i = 1'b1;
    do_reset(1'b0);
    rst_ni = 1'b0;
    #1;
    chk("R10", "pme_pull_o", pme_pull_o, 1'b0);
    chk("R10", "irq_o", irq_o, 1'b0);
    chk("R10", "suspend_o", suspend_o, 1'b0);
    chk("R10", "suspend_n_o", suspend_n_o, 1'b1);
    chk("R10", "active_o", active_o, 1'b1);
    cyc(1);
    rst_ni = 1'b1;
    cyc(10);
    chk("R1", "irq_o after high level at release", irq_o, 1'b0);
    detect_i = 1'b0;
    cyc(6);
    exp_irq = 1'b0;
    exp_pme = 1'b0;

    // R4 exact latency: rise before edge 1, flag visible after edge 3
    pme_en_i = 1'b0;
    detect_i = 1'b1;
    cyc(2);
    chk("R4", "irq_o after two edges", irq_o, 1'b0);
    cyc(1);
    chk("R4", "irq_o after three edges", irq_o, 1'b1);
    chk("R3", "pme_pull_o with enable off", pme_pull_o, 1'b0);
    // R1 sustained level: one event only
    cyc(4);
    clear_pulse();
    cyc(10);
    chk("R1", "irq_o with held level", irq_o, 1'b0);
    detect_i = 1'b0;
    cyc(6);

    // R2 R3 R4 R5 constrained random in PCI mode
    for (int i = 0; i < 40; i++) begin
      int op;
      op = $urandom_range(0, 3);
      pme_en_i = 1'($urandom_range(0, 1));
      cyc(1);
      if (op <= 1) begin
        model_wake_pci(pme_en_i);
        wake_pulse();
        chk_pci(pme_en_i ? "R2" : "R3");
      end else if (op == 2) begin
        model_clear();
        clear_pulse();
        chk_pci("R5");
      end else begin
        cyc(8);
        chk_pci("R5 hold");
      end
    end

    // R5 clear timing
    pme_en_i = 1'b1;
    wake_pulse();
    evt_clr_i = 1'b1;
    cyc(1);
    evt_clr_i = 1'b0;
    chk("R5", "irq_o one edge after clear", irq_o, 1'b0);
    cyc(1);
    chk("R5", "pme_pull_o two edges after clear", pme_pull_o, 1'b0);
    cyc(2);

    // R9 suspend request ignored in PCI; R11 late strap change ignored
    usb_mode_i = 1'b1;
    cyc(2);
    req_pulse();
    chk("R9", "suspend_o", suspend_o, 1'b0);
    chk("R11", "active_o after strap change", active_o, 1'b1);
    wake_pulse();
    chk("R11", "irq_o still PCI behaviour", irq_o, 1'b1);
    clear_pulse();
    usb_mode_i = 1'b0;

    // R6 PME with clock stopped
    pme_en_i = 1'b1;
    @(negedge clk);
    clk_run = 1'b0;
    #20;
    detect_i = 1'b1;
    #20;
    chk("R6", "pme_pull_o clock stopped", pme_pull_o, 1'b1);
    chk("R6", "irq_o waits for clock", irq_o, 1'b0);
    clk_run = 1'b1;
    cyc(6);
    chk("R4", "irq_o after clock resumes", irq_o, 1'b1);
    detect_i = 1'b0;
    cyc(4);
    clear_pulse();

    // USB mode: R7 R8 directed then random
    do_reset(1'b1);
    cyc(6);
    exp_susp = 1'b0;
    chk_usb("R10");
    pme_en_i = 1'b1;
    suspend_req_i = 1'b1;
    cyc(1);
    suspend_req_i = 1'b0;
    chk("R7", "suspend_o next edge", suspend_o, 1'b1);
    chk("R7", "active_o next edge", active_o, 1'b0);
    exp_susp = 1'b1;
    wake_pulse();
    exp_susp = 1'b0;
    chk_usb("R8");

    for (int i = 0; i < 40; i++) begin
      int op;
      op = $urandom_range(0, 2);
      pme_en_i = 1'($urandom_range(0, 1));
      if (op == 0) begin
        req_pulse();
        exp_susp = 1'b1;
        chk_usb("R7");
      end else if (op == 1) begin
        wake_pulse();
        exp_susp = 1'b0;
        chk_usb("R8");
      end else begin
        clear_pulse();
        chk_usb("R8 clear");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule